// File: doc/BRIEF.md
# Program and Pattern Bank Address Translator

This block turns processor and video-side bus addresses into physical memory addresses for a banked cartridge. Its inputs are the mapper's configuration values after they have been loaded: a 5-bit control word, a 5-bit program bank word and two 5-bit pattern bank words. The block is purely combinational. A new result is ready as soon as an address or a configuration value changes.

On the processor side, an access in 0x8000–0xFFFF becomes an 18-bit program ROM address. The layout is one of three program modes:
- **whole-32K**: one switchable 32 KiB window.
- **fixed-first**: 16 KiB page 0 sits at 0x8000, and the switchable page sits at 0xC000.
- **fixed-last**: the switchable page sits at 0x8000, and the highest page sits at 0xC000.

The decode for 0x6000–0x7FFF drives a work-RAM enable. A disable bit in the program bank word can force this enable low.

On the video side, an access in 0x0000–0x1FFF becomes a 17-bit pattern address. The layout is one of two pattern modes:
- **one-8K**: a single 8 KiB bank.
- **two-4K**: two independent 4 KiB halves.

The two mirroring bits select which of two internal nametable pages a video access uses.

Top module: `bank_xlat`

## Requirements
- R1: Control bit 3 = 0 selects whole-32K mode. The 16 KiB page index is {prog_bank[3:1], cpu_addr[14]}. Program bank bit 0 and control bit 2 are ignored.
- R2: Control bit 3 = 1 with control bit 2 = 0 selects fixed-first mode. When cpu_addr[14] = 0 the page index is 0. When cpu_addr[14] = 1 the page index is prog_bank[3:0].
- R3: Control bit 3 = 1 with control bit 2 = 1 selects fixed-last mode. When cpu_addr[14] = 0 the page index is prog_bank[3:0]. When cpu_addr[14] = 1 the page index is 0xF.
- R4: The program address is {page index, cpu_addr[13:0]}. prg_sel equals 1 exactly when cpu_addr is at or above 0x8000.
- R5: Control bit 4 = 0 selects one-8K pattern mode. The 4 KiB index is {pat_bank0[4:1], ppu_addr[12]}. pat_bank1 is ignored.
- R6: Control bit 4 = 1 selects two-4K pattern mode. pat_bank0 maps 0x0000–0x0FFF and pat_bank1 maps 0x1000–0x1FFF. The pattern address is {index, ppu_addr[11:0]}.
- R7: Control bits 1..0 encode the mirroring: 00 gives nt_page = 0, 01 gives nt_page = 1, 10 gives nt_page = ppu_addr[10], and 11 gives nt_page = ppu_addr[11].
- R8: wram_en is 1 exactly when cpu_addr lies in 0x6000–0x7FFF and prog_bank bit 4 (the RAM disable) is 0.
- R9: pat_sel is 1 exactly when ppu_addr is below 0x2000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_reg | input | 5 | Control word: [4] pattern mode, [3] program size, [2] slot, [1:0] mirroring |
| prog_bank | input | 5 | [3:0] program page, [4] work-RAM disable |
| pat_bank0 | input | 5 | First pattern bank (4 KiB units) |
| pat_bank1 | input | 5 | Second pattern bank (4 KiB units) |
| cpu_addr | input | 16 | Processor bus address |
| ppu_addr | input | 14 | Video bus address |
| prg_addr | output | 18 | Program ROM address |
| prg_sel | output | 1 | Program ROM window hit |
| pat_addr | output | 17 | Pattern memory address |
| pat_sel | output | 1 | Pattern window hit |
| nt_page | output | 1 | Nametable page select |
| wram_en | output | 1 | Work-RAM enable |

## Verification
The block holds no state, so any fault in the mode decode shows up on prg_addr, pat_addr or nt_page for the same address and configuration that exposes it. A wrong mode shows as a wrong upper page field only in the half of a window where the two candidate modes differ. For that reason, random addresses must cover both halves of every window under every mode. A bad RAM gate shows on wram_en only at the window edges and only with the disable bit in each state.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;
    typedef enum logic [1:0] {
        PRG_WHOLE32   = 2'd0,
        PRG_FIX_FIRST = 2'd1,
        PRG_FIX_LAST  = 2'd2
    } prg_mode_e;

    typedef enum logic {
        PAT_ONE8K = 1'b0,
        PAT_TWO4K = 1'b1
    } pat_mode_e;

    typedef enum logic [1:0] {
        MIR_SINGLE_LO = 2'd0,
        MIR_SINGLE_HI = 2'd1,
        MIR_VERT      = 2'd2,
        MIR_HORZ      = 2'd3
    } mirror_e;
endpackage

// File: rtl/bank_xlat_prg.sv
module bank_xlat_prg
    import bank_xlat_pkg::*;
#(
    parameter int BANK_W  = 4,
    parameter int PAGE_AW = 14
) (
    input  prg_mode_e                   mode,
    input  logic [BANK_W-1:0]           bank,
    input  logic [PAGE_AW:0]            offs,
    output logic [BANK_W+PAGE_AW-1:0]   addr
);
    localparam logic [BANK_W-1:0] LAST_PAGE = '1;

    logic              upper_half;
    logic [BANK_W-1:0] page;

    assign upper_half = offs[PAGE_AW];

    always_comb begin
        unique case (mode)
            PRG_WHOLE32:   page = {bank[BANK_W-1:1], upper_half};
            PRG_FIX_FIRST: page = upper_half ? bank : '0;
            PRG_FIX_LAST:  page = upper_half ? LAST_PAGE : bank;
            default:       page = bank;
        endcase
    end

    assign addr = {page, offs[PAGE_AW-1:0]};
endmodule

// File: rtl/bank_xlat_pat.sv
module bank_xlat_pat
    import bank_xlat_pkg::*;
#(
    parameter int BANK_W  = 5,
    parameter int PAGE_AW = 12
) (
    input  pat_mode_e                   mode,
    input  logic [BANK_W-1:0]           bank_lo,
    input  logic [BANK_W-1:0]           bank_hi,
    input  logic [PAGE_AW:0]            offs,
    output logic [BANK_W+PAGE_AW-1:0]   addr
);
    logic              upper_half;
    logic [BANK_W-1:0] page;

    assign upper_half = offs[PAGE_AW];

    always_comb begin
        unique case (mode)
            PAT_ONE8K: page = {bank_lo[BANK_W-1:1], upper_half};
            PAT_TWO4K: page = upper_half ? bank_hi : bank_lo;
            default:   page = bank_lo;
        endcase
    end

    assign addr = {page, offs[PAGE_AW-1:0]};
endmodule

// File: rtl/bank_xlat_side.sv
module bank_xlat_side
    import bank_xlat_pkg::*;
(
    input  mirror_e     mirror,
    input  logic [1:0]  vid_a11_a10,
    input  logic [2:0]  cpu_top3,
    input  logic        ram_off,
    output logic        nt_page,
    output logic        wram_en
);
    always_comb begin
        unique case (mirror)
            MIR_SINGLE_LO: nt_page = 1'b0;
            MIR_SINGLE_HI: nt_page = 1'b1;
            MIR_VERT:      nt_page = vid_a11_a10[0];
            MIR_HORZ:      nt_page = vid_a11_a10[1];
            default:       nt_page = 1'b0;
        endcase
    end

    assign wram_en = (cpu_top3 == 3'b011) && !ram_off;
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
    import bank_xlat_pkg::*;
#(
    parameter int PRG_BANK_W  = 4,
    parameter int PRG_PAGE_AW = 14,
    parameter int PAT_BANK_W  = 5,
    parameter int PAT_PAGE_AW = 12,
    localparam int PRG_AW = PRG_BANK_W + PRG_PAGE_AW,
    localparam int PAT_AW = PAT_BANK_W + PAT_PAGE_AW
) (
    input  logic [4:0]          ctrl_reg,
    input  logic [4:0]          prog_bank,
    input  logic [4:0]          pat_bank0,
    input  logic [4:0]          pat_bank1,
    input  logic [15:0]         cpu_addr,
    input  logic [13:0]         ppu_addr,
    output logic [PRG_AW-1:0]   prg_addr,
    output logic                prg_sel,
    output logic [PAT_AW-1:0]   pat_addr,
    output logic                pat_sel,
    output logic                nt_page,
    output logic                wram_en
);
    prg_mode_e prg_mode;
    pat_mode_e pat_mode;
    mirror_e   mir_mode;

    always_comb begin
        if (!ctrl_reg[3])
            prg_mode = PRG_WHOLE32;
        else if (ctrl_reg[2])
            prg_mode = PRG_FIX_LAST;
        else
            prg_mode = PRG_FIX_FIRST;
    end

    assign pat_mode = pat_mode_e'(ctrl_reg[4]);
    assign mir_mode = mirror_e'(ctrl_reg[1:0]);

    bank_xlat_prg #(.BANK_W(PRG_BANK_W), .PAGE_AW(PRG_PAGE_AW)) u_prg (
        .mode (prg_mode),
        .bank (prog_bank[PRG_BANK_W-1:0]),
        .offs (cpu_addr[PRG_PAGE_AW:0]),
        .addr (prg_addr)
    );

    bank_xlat_pat #(.BANK_W(PAT_BANK_W), .PAGE_AW(PAT_PAGE_AW)) u_pat (
        .mode    (pat_mode),
        .bank_lo (pat_bank0[PAT_BANK_W-1:0]),
        .bank_hi (pat_bank1[PAT_BANK_W-1:0]),
        .offs    (ppu_addr[PAT_PAGE_AW:0]),
        .addr    (pat_addr)
    );

    bank_xlat_side u_side (
        .mirror      (mir_mode),
        .vid_a11_a10 (ppu_addr[11:10]),
        .cpu_top3    (cpu_addr[15:13]),
        .ram_off     (prog_bank[4]),
        .nt_page     (nt_page),
        .wram_en     (wram_en)
    );

    assign prg_sel = cpu_addr[15];
    assign pat_sel = (ppu_addr[13] == 1'b0);
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk #(
    parameter int PRG_BANK_W  = 4,
    parameter int PRG_PAGE_AW = 14,
    parameter int PAT_BANK_W  = 5,
    parameter int PAT_PAGE_AW = 12
) (
    input logic [4:0]                        ctrl_reg,
    input logic [4:0]                        prog_bank,
    input logic [4:0]                        pat_bank1,
    input logic [15:0]                       cpu_addr,
    input logic [13:0]                       ppu_addr,
    input logic [PRG_BANK_W+PRG_PAGE_AW-1:0] prg_addr,
    input logic [PAT_BANK_W+PAT_PAGE_AW-1:0] pat_addr,
    input logic                              nt_page,
    input logic                              wram_en
);
    localparam int PRG_AW = PRG_BANK_W + PRG_PAGE_AW;
    localparam int PAT_AW = PAT_BANK_W + PAT_PAGE_AW;

    logic [PRG_BANK_W-1:0] prg_page;
    assign prg_page = prg_addr[PRG_AW-1:PRG_PAGE_AW];

    always_comb begin
        if (!ctrl_reg[3])
            assert_whole_half_R1: assert (prg_page[0] == cpu_addr[PRG_PAGE_AW]);
        if (ctrl_reg[3] && !ctrl_reg[2] && !cpu_addr[PRG_PAGE_AW])
            assert_first_fixed_R2: assert (prg_page == '0);
        if (ctrl_reg[3] && ctrl_reg[2] && cpu_addr[PRG_PAGE_AW])
            assert_last_fixed_R3: assert (&prg_page);
        assert_offset_pass_R4: assert (prg_addr[PRG_PAGE_AW-1:0] == cpu_addr[PRG_PAGE_AW-1:0]);
        if (ctrl_reg[4] && ppu_addr[PAT_PAGE_AW])
            assert_upper_bank_R6: assert (pat_addr[PAT_AW-1:PAT_PAGE_AW] == pat_bank1[PAT_BANK_W-1:0]);
        if (!ctrl_reg[1])
            assert_single_screen_R7: assert (nt_page == ctrl_reg[0]);
        if (wram_en)
            assert_ram_gate_R8: assert (!prog_bank[4] && cpu_addr[15:13] == 3'b011);
    end
endmodule

bind bank_xlat bank_xlat_chk #(
    .PRG_BANK_W (PRG_BANK_W),
    .PRG_PAGE_AW(PRG_PAGE_AW),
    .PAT_BANK_W (PAT_BANK_W),
    .PAT_PAGE_AW(PAT_PAGE_AW)
) u_chk (
    .ctrl_reg (ctrl_reg),
    .prog_bank(prog_bank),
    .pat_bank1(pat_bank1),
    .cpu_addr (cpu_addr),
    .ppu_addr (ppu_addr),
    .prg_addr (prg_addr),
    .pat_addr (pat_addr),
    .nt_page  (nt_page),
    .wram_en  (wram_en)
);

// File: tb/tb_bank_xlat.sv
`timescale 1ns/1ps
module tb_bank_xlat;
    logic        clk = 1'b0;
    logic [4:0]  ctrl_reg = '0;
    logic [4:0]  prog_bank = '0;
    logic [4:0]  pat_bank0 = '0;
    logic [4:0]  pat_bank1 = '0;
    logic [15:0] cpu_addr = '0;
    logic [13:0] ppu_addr = '0;
    logic [17:0] prg_addr;
    logic        prg_sel;
    logic [16:0] pat_addr;
    logic        pat_sel;
    logic        nt_page;
    logic        wram_en;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_xlat dut (
        .ctrl_reg(ctrl_reg), .prog_bank(prog_bank),
        .pat_bank0(pat_bank0), .pat_bank1(pat_bank1),
        .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
        .prg_addr(prg_addr), .prg_sel(prg_sel),
        .pat_addr(pat_addr), .pat_sel(pat_sel),
        .nt_page(nt_page), .wram_en(wram_en)
    );

    function automatic logic [17:0] exp_prg(input logic [4:0] c, input logic [4:0] p, input logic [15:0] a);
        logic [3:0] pg;
        if (!c[3])      pg = {p[3:1], a[14]};
        else if (!c[2]) pg = a[14] ? p[3:0] : 4'h0;
        else            pg = a[14] ? 4'hF : p[3:0];
        return {pg, a[13:0]};
    endfunction

    function automatic logic [16:0] exp_pat(input logic [4:0] c, input logic [4:0] b0, input logic [4:0] b1, input logic [13:0] a);
        logic [4:0] pg;
        if (!c[4]) pg = {b0[4:1], a[12]};
        else       pg = a[12] ? b1 : b0;
        return {pg, a[11:0]};
    endfunction

    function automatic logic exp_nt(input logic [4:0] c, input logic [13:0] a);
        case (c[1:0])
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return a[10];
            default: return a[11];
        endcase
    endfunction

    function automatic logic exp_ram(input logic [4:0] p, input logic [15:0] a);
        return (a >= 16'h6000) && (a <= 16'h7FFF) && !p[4];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (ctrl=%0h prog=%0h cpu=%0h ppu=%0h)",
                     tag, act, exp, ctrl_reg, prog_bank, cpu_addr, ppu_addr);
        end
    endtask

    task automatic apply(input logic [4:0] c, input logic [4:0] p, input logic [4:0] b0,
                         input logic [4:0] b1, input logic [15:0] ca, input logic [13:0] pa);
        @(posedge clk);
        #1;
        ctrl_reg = c; prog_bank = p; pat_bank0 = b0; pat_bank1 = b1;
        cpu_addr = ca; ppu_addr = pa;
        @(negedge clk);
    endtask

    task automatic check_all();
        string ptag;
        if (!ctrl_reg[3])      ptag = "R1";
        else if (!ctrl_reg[2]) ptag = "R2";
        else                   ptag = "R3";
        chk(ptag, 32'(prg_addr), 32'(exp_prg(ctrl_reg, prog_bank, cpu_addr)));
        chk("R4", 32'(prg_sel), 32'(cpu_addr >= 16'h8000));
        if (!ctrl_reg[4]) chk("R5", 32'(pat_addr), 32'(exp_pat(ctrl_reg, pat_bank0, pat_bank1, ppu_addr)));
        else              chk("R6", 32'(pat_addr), 32'(exp_pat(ctrl_reg, pat_bank0, pat_bank1, ppu_addr)));
        chk("R7", 32'(nt_page), 32'(exp_nt(ctrl_reg, ppu_addr)));
        chk("R8", 32'(wram_en), 32'(exp_ram(prog_bank, cpu_addr)));
        chk("R9", 32'(pat_sel), 32'(ppu_addr < 14'h2000));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // all-zero start state
        @(negedge clk);
        chk("R1", 32'(prg_addr), 32'h0);
        chk("R7", 32'(nt_page), 32'h0);
        chk("R8", 32'(wram_en), 32'h0);
        chk("R9", 32'(pat_sel), 32'h1);
        // R3 fixed-last, both halves
        apply(5'h0C, 5'h05, 5'h00, 5'h00, 16'hC123, 14'h0000);
        chk("R3", 32'(prg_addr), 32'h3C123);
        apply(5'h0C, 5'h05, 5'h00, 5'h00, 16'h8123, 14'h0000);
        chk("R3", 32'(prg_addr), 32'h14123);
        // R2 fixed-first low half forced to page 0
        apply(5'h08, 5'h0B, 5'h00, 5'h00, 16'h8FFF, 14'h0000);
        chk("R2", 32'(prg_addr), 32'h00FFF);
        // R1 whole-32K with slot bit set and odd bank: bit 0 and slot ignored
        apply(5'h04, 5'h07, 5'h00, 5'h00, 16'h8001, 14'h0000);
        chk("R1", 32'(prg_addr), 32'h18001);
        // R5 one-8K with odd bank0, bank1 ignored
        apply(5'h00, 5'h00, 5'h0B, 5'h1F, 16'h0000, 14'h1ABC);
        chk("R5", 32'(pat_addr), 32'h0BABC);
        // R6 two-4K upper half from bank1
        apply(5'h10, 5'h00, 5'h0B, 5'h13, 16'h0000, 14'h1ABC);
        chk("R6", 32'(pat_addr), 32'h13ABC);
        // R8 window edges and disable
        apply(5'h00, 5'h00, 5'h00, 5'h00, 16'h6000, 14'h0000);
        chk("R8", 32'(wram_en), 32'h1);
        apply(5'h00, 5'h00, 5'h00, 5'h00, 16'h7FFF, 14'h0000);
        chk("R8", 32'(wram_en), 32'h1);
        apply(5'h00, 5'h00, 5'h00, 5'h00, 16'h5FFF, 14'h0000);
        chk("R8", 32'(wram_en), 32'h0);
        apply(5'h00, 5'h10, 5'h00, 5'h00, 16'h6800, 14'h0000);
        chk("R8", 32'(wram_en), 32'h0);
        // R7 vertical and horizontal
        apply(5'h02, 5'h00, 5'h00, 5'h00, 16'h0000, 14'h2400);
        chk("R7", 32'(nt_page), 32'h1);
        apply(5'h03, 5'h00, 5'h00, 5'h00, 16'h0000, 14'h2400);
        chk("R7", 32'(nt_page), 32'h0);
        chk("R9", 32'(pat_sel), 32'h0);
        // constrained random sweep
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ca;
            logic [13:0] pa;
            ca = 16'($urandom);
            pa = 14'($urandom);
            if (i % 4 == 0) ca = {3'b011, ca[12:0]};
            if (i % 3 == 0) pa = {1'b0, pa[12:0]};
            apply(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom), ca, pa);
            check_all();
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule